// File: doc/BRIEF.md
# Tag-Broadcast Reservation Station Core

This block is the scheduling heart of an out-of-order execution core that renames registers in hardware. Operations leave an in-order queue one at a time and each is placed into a free reservation station of the matching class. A station holds, for each of its two sources, either the operand value or the tag of the station that will produce it. A station starts its fixed-latency countdown once both operands are present, then competes for a single result bus that carries a producer tag together with a 64-bit result.

Every waiting station snoops the bus and takes any result whose tag it is waiting for. The architectural register file keeps one pending-writer tag per register. A broadcast updates a register only while that register still names the broadcasting station, so an older result never overwrites a register renamed since. Because sources are renamed to tags at issue time, write-after-read and write-after-write conflicts never stall issue. A registered read port lets the surrounding core observe committed register contents.

Top module: `rsv_core`

## Requirements
- R1: After reset no station is occupied, `iss_ready_o` is 1 for every operation code, `bus_valid_o` is 0 and register i holds the value i.
- R2: Issue is in order, and an operation is accepted at a clock edge only when `iss_valid_i` and `iss_ready_o` are both 1. Codes 0 (add) and 1 (subtract) take the lowest free adder station, tags 1 to 3. Codes 2 (multiply) and 3 (divide) take the lowest free multiply/divide station, tags 4 and 5. `iss_ready_o` is 0 when the class selected by `iss_op_i` has no free station.
- R3: At issue, each source is taken as a value when its register has no pending writer, or when the pending writer's tag is on the bus in that same cycle; otherwise the pending writer's tag is held instead.
- R4: A station counts down only once both operands are values. Latency is 2 for add and subtract, 10 for multiply and 40 for divide. An uncontended result is on the bus in the cycle after edge S+L+1, where S is the edge at which the last operand became a value (the issue edge when both were ready) and L is the latency.
- R5: At most one result is broadcast per cycle, as a nonzero 4-bit tag with 64-bit data. When several stations finish together the lowest tag goes first and the others keep their results for the following cycles.
- R6: Every occupied station whose source tag equals the broadcast tag takes the bus data as that operand.
- R7: A broadcast writes a register only if that register's pending-writer tag equals the broadcast tag; otherwise the register keeps its value.
- R8: Issue overwrites the destination register's pending-writer tag with the new station's tag, so among several writers of one register only the last issued one updates it.
- R9: A station stays occupied through its broadcast cycle and is free for a new issue from the edge that ends that cycle.
- R10: Results are the low 64 bits of a+b, a-b and a*b, and the unsigned quotient a/b; a zero divisor yields all ones.
- R11: `rd_data_o` shows, one cycle later, the value register `rd_addr_i` held just before the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid_i | input | 1 | An operation is offered for issue |
| iss_op_i | input | 2 | Operation code: 0 add, 1 subtract, 2 multiply, 3 divide |
| iss_dst_i | input | 3 | Destination register |
| iss_src1_i | input | 3 | First source register |
| iss_src2_i | input | 3 | Second source register |
| iss_ready_o | output | 1 | A station of the class of `iss_op_i` is free |
| bus_valid_o | output | 1 | A result is being broadcast |
| bus_tag_o | output | 4 | Tag of the broadcasting station |
| bus_data_o | output | 64 | Broadcast result |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 64 | Registered register read data |

## Verification
An operation whose operands are ready at issue edge E appears on the bus in the cycle after edge E+L+1. A dependent station takes that value at the edge closing the broadcast cycle and begins its own countdown one edge later. Register contents show on the read port one cycle after the address is presented. The bench drives inputs just after the falling edge and compares bus, ready and read data a short delay later against a behavioural model stepped on each rising edge. Directed checks count falling edges from issue to pin down the add latency, the back-to-back order of two stations finishing together, and the bus bypass taken when a consumer issues during its producer's broadcast.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_DIV = 2'd3
  } op_e;
endpackage

// File: rtl/rsv_arbiter.sv
module rsv_arbiter #(
  parameter int N = 5
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o
);
  logic found;

  // lowest index wins
  always_comb begin
    grant_o = '0;
    found   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        grant_o[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rsv_station.sv
module rsv_station
  import rsv_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int TAG_W   = 4,
  parameter bit IS_MUL  = 1'b0,
  parameter int ADD_LAT = 2,
  parameter int MUL_LAT = 10,
  parameter int DIV_LAT = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_i,
  input  op_e               alloc_op_i,
  input  logic [DATA_W-1:0] vj_i,
  input  logic [DATA_W-1:0] vk_i,
  input  logic [TAG_W-1:0]  qj_i,
  input  logic [TAG_W-1:0]  qk_i,
  input  logic              bus_valid_i,
  input  logic [TAG_W-1:0]  bus_tag_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              grant_i,
  output logic              busy_o,
  output logic              req_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int MAX_AM  = (ADD_LAT > MUL_LAT) ? ADD_LAT : MUL_LAT;
  localparam int MAX_LAT = (DIV_LAT > MAX_AM) ? DIV_LAT : MAX_AM;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  logic              busy_q, running_q, sent_q;
  op_e               op_q;
  logic [DATA_W-1:0] vj_q, vk_q;
  logic [TAG_W-1:0]  qj_q, qk_q;
  logic [CNT_W-1:0]  cnt_q, lat_m1;

  always_comb begin
    case (op_q)
      OP_MUL:  lat_m1 = CNT_W'(MUL_LAT - 1);
      OP_DIV:  lat_m1 = CNT_W'(DIV_LAT - 1);
      default: lat_m1 = CNT_W'(ADD_LAT - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      running_q <= 1'b0;
      sent_q    <= 1'b0;
      op_q      <= OP_ADD;
      vj_q      <= '0;
      vk_q      <= '0;
      qj_q      <= '0;
      qk_q      <= '0;
      cnt_q     <= '0;
    end else if (alloc_i) begin
      busy_q    <= 1'b1;
      running_q <= 1'b0;
      sent_q    <= 1'b0;
      op_q      <= alloc_op_i;
      vj_q      <= vj_i;
      vk_q      <= vk_i;
      qj_q      <= qj_i;
      qk_q      <= qk_i;
      cnt_q     <= '0;
    end else if (busy_q) begin
      if (sent_q) begin
        busy_q    <= 1'b0;
        sent_q    <= 1'b0;
        running_q <= 1'b0;
      end
      if (bus_valid_i && qj_q != '0 && qj_q == bus_tag_i) begin
        vj_q <= bus_data_i;
        qj_q <= '0;
      end
      if (bus_valid_i && qk_q != '0 && qk_q == bus_tag_i) begin
        vk_q <= bus_data_i;
        qk_q <= '0;
      end
      if (!running_q && qj_q == '0 && qk_q == '0) begin
        running_q <= 1'b1;
        cnt_q     <= lat_m1;
      end else if (running_q && cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (grant_i) sent_q <= 1'b1;
    end
  end

  generate
    if (IS_MUL) begin : g_muldiv
      always_comb begin
        if (op_q == OP_DIV) result_o = (vk_q == '0) ? '1 : (vj_q / vk_q);
        else                result_o = vj_q * vk_q;
      end
    end else begin : g_addsub
      always_comb begin
        if (op_q == OP_SUB) result_o = vj_q - vk_q;
        else                result_o = vj_q + vk_q;
      end
    end
  endgenerate

  assign busy_o = busy_q;
  assign req_o  = busy_q && running_q && (cnt_q == '0) && !sent_q;

  // R2
  alloc_free_chk: assert property (@(posedge clk) disable iff (rst)
    alloc_i |-> !busy_q);
  // R4
  start_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(running_q) |-> ($past(qj_q) == '0 && $past(qk_q) == '0));
  // R6
  capture_j_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !alloc_i && bus_valid_i && qj_q != '0 && qj_q == bus_tag_i)
      |=> (qj_q == '0 && vj_q == $past(bus_data_i)));
  // R6
  capture_k_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !alloc_i && bus_valid_i && qk_q != '0 && qk_q == bus_tag_i)
      |=> (qk_q == '0 && vk_q == $past(bus_data_i)));
  // R9
  free_after_send_chk: assert property (@(posedge clk) disable iff (rst)
    sent_q |=> !busy_q);
  // R9
  hold_until_send_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !sent_q) |=> busy_q);
endmodule

// File: rtl/rsv_regfile.sv
module rsv_regfile #(
  parameter int DATA_W   = 64,
  parameter int TAG_W    = 4,
  parameter int NUM_REGS = 8,
  parameter int REG_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid_i,
  input  logic [TAG_W-1:0]  bus_tag_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              ren_en_i,
  input  logic [REG_W-1:0]  ren_reg_i,
  input  logic [TAG_W-1:0]  ren_tag_i,
  input  logic [REG_W-1:0]  src1_i,
  input  logic [REG_W-1:0]  src2_i,
  output logic [DATA_W-1:0] src1_val_o,
  output logic [TAG_W-1:0]  src1_stat_o,
  output logic [DATA_W-1:0] src2_val_o,
  output logic [TAG_W-1:0]  src2_stat_o,
  input  logic [REG_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic [TAG_W-1:0]  stat_q [NUM_REGS];

  assign src1_val_o  = regs_q[src1_i];
  assign src1_stat_o = stat_q[src1_i];
  assign src2_val_o  = regs_q[src2_i];
  assign src2_stat_o = stat_q[src2_i];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        regs_q[r] <= DATA_W'(r);
        stat_q[r] <= '0;
      end
      rd_data_o <= '0;
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (bus_valid_i && stat_q[r] == bus_tag_i) begin
          regs_q[r] <= bus_data_i;
          stat_q[r] <= '0;
        end
      end
      if (ren_en_i) stat_q[ren_reg_i] <= ren_tag_i;
      rd_data_o <= regs_q[rd_addr_i];
    end
  end

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_chk
      // R7
      reg_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid_i && stat_q[g] != '0 && stat_q[g] == bus_tag_i)
          |=> (regs_q[g] == $past(bus_data_i)));
      // R7
      reg_miss_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid_i && stat_q[g] == bus_tag_i) |=> $stable(regs_q[g]));
      // R8
      rename_chk: assert property (@(posedge clk) disable iff (rst)
        (ren_en_i && ren_reg_i == REG_W'(g)) |=> (stat_q[g] == $past(ren_tag_i)));
    end
  endgenerate
endmodule

// File: rtl/rsv_core.sv
module rsv_core
  import rsv_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int TAG_W    = 4,
  parameter int NUM_REGS = 8,
  parameter int NUM_ADD  = 3,
  parameter int NUM_MUL  = 2,
  parameter int ADD_LAT  = 2,
  parameter int MUL_LAT  = 10,
  parameter int DIV_LAT  = 40,
  parameter int REG_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid_i,
  input  logic [1:0]        iss_op_i,
  input  logic [REG_W-1:0]  iss_dst_i,
  input  logic [REG_W-1:0]  iss_src1_i,
  input  logic [REG_W-1:0]  iss_src2_i,
  output logic              iss_ready_o,
  output logic              bus_valid_o,
  output logic [TAG_W-1:0]  bus_tag_o,
  output logic [DATA_W-1:0] bus_data_o,
  input  logic [REG_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int NUM_RS = NUM_ADD + NUM_MUL;

  logic [NUM_RS-1:0] busy, req, grant, pick;
  logic [DATA_W-1:0] result [NUM_RS];
  logic [TAG_W-1:0]  pick_tag, win_tag;
  logic [DATA_W-1:0] win_data;
  logic              found, fire, want_md;
  op_e               iss_op;
  logic [DATA_W-1:0] s1_val, s2_val, vj, vk;
  logic [TAG_W-1:0]  s1_stat, s2_stat, qj, qk;

  assign iss_op  = op_e'(iss_op_i);
  assign want_md = iss_op_i[1];

  // lowest free station of the requested class
  always_comb begin
    pick     = '0;
    pick_tag = '0;
    found    = 1'b0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (!found && !busy[i] && ((i >= NUM_ADD) == want_md)) begin
        pick[i]  = 1'b1;
        pick_tag = TAG_W'(i + 1);
        found    = 1'b1;
      end
    end
  end

  assign iss_ready_o = found;
  assign fire        = iss_valid_i && found;

  // source resolution with same-cycle bus bypass
  always_comb begin
    vj = '0; qj = '0;
    if (s1_stat == '0)                             vj = s1_val;
    else if (bus_valid_o && bus_tag_o == s1_stat)  vj = bus_data_o;
    else                                           qj = s1_stat;
    vk = '0; qk = '0;
    if (s2_stat == '0)                             vk = s2_val;
    else if (bus_valid_o && bus_tag_o == s2_stat)  vk = bus_data_o;
    else                                           qk = s2_stat;
  end

  rsv_regfile #(
    .DATA_W(DATA_W), .TAG_W(TAG_W), .NUM_REGS(NUM_REGS), .REG_W(REG_W)
  ) i_regfile (
    .clk(clk), .rst(rst),
    .bus_valid_i(bus_valid_o), .bus_tag_i(bus_tag_o), .bus_data_i(bus_data_o),
    .ren_en_i(fire), .ren_reg_i(iss_dst_i), .ren_tag_i(pick_tag),
    .src1_i(iss_src1_i), .src2_i(iss_src2_i),
    .src1_val_o(s1_val), .src1_stat_o(s1_stat),
    .src2_val_o(s2_val), .src2_stat_o(s2_stat),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  generate
    for (genvar s = 0; s < NUM_RS; s++) begin : g_rs
      rsv_station #(
        .DATA_W(DATA_W), .TAG_W(TAG_W), .IS_MUL(s >= NUM_ADD),
        .ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT), .DIV_LAT(DIV_LAT)
      ) i_station (
        .clk(clk), .rst(rst),
        .alloc_i(fire && pick[s]), .alloc_op_i(iss_op),
        .vj_i(vj), .vk_i(vk), .qj_i(qj), .qk_i(qk),
        .bus_valid_i(bus_valid_o), .bus_tag_i(bus_tag_o), .bus_data_i(bus_data_o),
        .grant_i(grant[s]),
        .busy_o(busy[s]), .req_o(req[s]), .result_o(result[s])
      );
    end
  endgenerate

  rsv_arbiter #(.N(NUM_RS)) i_arbiter (.req_i(req), .grant_o(grant));

  always_comb begin
    win_tag  = '0;
    win_data = '0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (grant[i]) begin
        win_tag  = TAG_W'(i + 1);
        win_data = result[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_valid_o <= 1'b0;
      bus_tag_o   <= '0;
      bus_data_o  <= '0;
    end else begin
      bus_valid_o <= |grant;
      if (|grant) begin
        bus_tag_o  <= win_tag;
        bus_data_o <= win_data;
      end
    end
  end

  // R5
  one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  // R5
  bus_tag_range_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid_o |-> (bus_tag_o != '0 && bus_tag_o <= TAG_W'(NUM_RS)));
  // R5
  waiter_keeps_req_chk: assert property (@(posedge clk) disable iff (rst)
    (req != '0 && (req & ~grant) != '0) |=> ((req & ~$past(grant)) != '0 || $past(req & ~grant) == '0));
endmodule

// File: tb/test_rsv_core.sv
module test_rsv_core;
  logic        clk = 1'b0;
  logic        rst;
  logic        iss_valid;
  logic [1:0]  iss_op;
  logic [2:0]  iss_dst, iss_src1, iss_src2;
  logic        iss_ready;
  logic        bus_valid;
  logic [3:0]  bus_tag;
  logic [63:0] bus_data;
  logic [2:0]  rd_addr;
  logic [63:0] rd_data;

  always #5 clk = ~clk;

  rsv_core i_rsv_core (
    .clk(clk), .rst(rst),
    .iss_valid_i(iss_valid), .iss_op_i(iss_op), .iss_dst_i(iss_dst),
    .iss_src1_i(iss_src1), .iss_src2_i(iss_src2), .iss_ready_o(iss_ready),
    .bus_valid_o(bus_valid), .bus_tag_o(bus_tag), .bus_data_o(bus_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  bit    run_chk = 1'b0;
  string cur_req = "R5";

  // behavioural reference model, stations indexed by tag
  bit          m_busy [1:5];
  bit          m_run  [1:5];
  bit          m_sent [1:5];
  int          m_op   [1:5];
  logic [63:0] m_vj   [1:5];
  logic [63:0] m_vk   [1:5];
  int          m_qj   [1:5];
  int          m_qk   [1:5];
  int          m_cnt  [1:5];
  logic [63:0] m_reg  [0:7];
  int          m_stat [0:7];
  bit          m_cv;
  int          m_ct;
  logic [63:0] m_cd, m_rd;
  bit          m_fire;

  function automatic int lat(int op);
    if (op == 2) return 10;
    if (op == 3) return 40;
    return 2;
  endfunction

  function automatic logic [63:0] alu(int op, logic [63:0] a, logic [63:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a * b;
      default: return (b == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : a / b;
    endcase
  endfunction

  function automatic bit m_ready(int op);
    for (int s = 1; s <= 5; s++)
      if (!m_busy[s] && ((s > 3) == (op >= 2))) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_reset();
    for (int s = 1; s <= 5; s++) begin
      m_busy[s] = 0; m_run[s] = 0; m_sent[s] = 0; m_op[s] = 0;
      m_vj[s] = 0; m_vk[s] = 0; m_qj[s] = 0; m_qk[s] = 0; m_cnt[s] = 0;
    end
    for (int r = 0; r < 8; r++) begin
      m_reg[r] = 64'(r);
      m_stat[r] = 0;
    end
    m_cv = 0; m_ct = 0; m_cd = 0; m_rd = 0; m_fire = 0;
  endtask

  task automatic model_step();
    int win = 0;
    int tgt = 0;
    logic [63:0] v1, v2, nd, nrd;
    int q1, q2;
    bit st;
    for (int s = 1; s <= 5; s++)
      if (win == 0 && m_busy[s] && m_run[s] && m_cnt[s] == 0 && !m_sent[s]) win = s;
    for (int s = 1; s <= 5; s++)
      if (tgt == 0 && !m_busy[s] && ((s > 3) == (iss_op >= 2))) tgt = s;
    m_fire = iss_valid && tgt != 0;
    if (m_stat[iss_src1] == 0) begin v1 = m_reg[iss_src1]; q1 = 0; end
    else if (m_cv && m_ct == m_stat[iss_src1]) begin v1 = m_cd; q1 = 0; end
    else begin v1 = 0; q1 = m_stat[iss_src1]; end
    if (m_stat[iss_src2] == 0) begin v2 = m_reg[iss_src2]; q2 = 0; end
    else if (m_cv && m_ct == m_stat[iss_src2]) begin v2 = m_cd; q2 = 0; end
    else begin v2 = 0; q2 = m_stat[iss_src2]; end
    nd  = (win != 0) ? alu(m_op[win], m_vj[win], m_vk[win]) : 64'd0;
    nrd = m_reg[rd_addr];
    for (int s = 1; s <= 5; s++) begin
      if (m_fire && s == tgt) begin
        m_busy[s] = 1; m_run[s] = 0; m_sent[s] = 0; m_op[s] = int'(iss_op);
        m_vj[s] = v1; m_vk[s] = v2; m_qj[s] = q1; m_qk[s] = q2; m_cnt[s] = 0;
      end else if (m_busy[s]) begin
        st = !m_run[s] && m_qj[s] == 0 && m_qk[s] == 0;
        if (m_sent[s]) begin m_busy[s] = 0; m_sent[s] = 0; m_run[s] = 0; end
        if (m_cv && m_qj[s] != 0 && m_qj[s] == m_ct) begin m_vj[s] = m_cd; m_qj[s] = 0; end
        if (m_cv && m_qk[s] != 0 && m_qk[s] == m_ct) begin m_vk[s] = m_cd; m_qk[s] = 0; end
        if (st) begin m_run[s] = 1; m_cnt[s] = lat(m_op[s]) - 1; end
        else if (m_run[s] && m_cnt[s] != 0) m_cnt[s]--;
        if (s == win) m_sent[s] = 1;
      end
    end
    for (int r = 0; r < 8; r++)
      if (m_cv && m_stat[r] == m_ct) begin m_reg[r] = m_cd; m_stat[r] = 0; end
    if (m_fire) m_stat[iss_dst] = tgt;
    m_cv = (win != 0);
    if (win != 0) begin m_ct = win; m_cd = nd; end
    m_rd = nrd;
  endtask

  always @(posedge clk) begin
    if (rst) model_reset();
    else     model_step();
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (!rst && run_chk && !done) begin
      chk(cur_req, 64'(bus_valid), 64'(m_cv));
      if (m_cv) begin
        chk(cur_req, 64'(bus_tag), 64'(m_ct));
        chk(cur_req, bus_data, m_cd);
      end
      chk("R2", 64'(iss_ready), 64'(m_ready(int'(iss_op))));
      chk("R11", rd_data, m_rd);
    end
  end

  task automatic issue(input logic [1:0] op, input logic [2:0] d,
                       input logic [2:0] a, input logic [2:0] b);
    iss_valid = 1'b1; iss_op = op; iss_dst = d; iss_src1 = a; iss_src2 = b;
    do @(negedge clk); while (!m_fire);
    iss_valid = 1'b0;
  endtask

  task automatic read_reg(input logic [2:0] a, output logic [63:0] v);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic wait_bcast(output logic [3:0] t, output logic [63:0] d);
    int n = 0;
    do begin @(negedge clk); n++; end while (!bus_valid && n < 200);
    t = bus_tag; d = bus_data;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic [3:0]  t;
    rst = 1'b1; iss_valid = 1'b0; iss_op = 2'd0;
    iss_dst = 3'd0; iss_src1 = 3'd0; iss_src2 = 3'd0; rd_addr = 3'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    run_chk = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", 64'(bus_valid), 64'd0);
    chk("R1", 64'(iss_ready), 64'd1);
    read_reg(3'd5, v);
    chk("R1", v, 64'd5);

    // R4: add latency, R10 add value
    cur_req = "R4";
    issue(2'd0, 3'd1, 3'd2, 3'd3);
    repeat (2) @(negedge clk);
    chk("R4", 64'(bus_valid), 64'd0);
    @(negedge clk);
    chk("R4", 64'(bus_valid), 64'd1);
    chk("R4", 64'(bus_tag), 64'd1);
    chk("R10", bus_data, 64'd5);
    repeat (2) @(negedge clk);

    // R7/R6: renamed destination ignores older multiply result
    cur_req = "R7";
    issue(2'd2, 3'd4, 3'd2, 3'd3);
    issue(2'd0, 3'd5, 3'd4, 3'd1);
    issue(2'd1, 3'd4, 3'd6, 3'd2);
    repeat (30) @(negedge clk);
    read_reg(3'd4, v);
    chk("R7", v, 64'd4);
    read_reg(3'd5, v);
    chk("R6", v, 64'd11);

    // R5: two stations finishing together, lowest tag first
    cur_req = "R5";
    issue(2'd2, 3'd6, 3'd2, 3'd2);
    issue(2'd0, 3'd1, 3'd6, 3'd0);
    issue(2'd0, 3'd2, 3'd6, 3'd3);
    wait_bcast(t, v);
    chk("R10", 64'(t), 64'd4);
    chk("R10", v, 64'd4);
    wait_bcast(t, v);
    chk("R5", 64'(t), 64'd1);
    chk("R6", v, 64'd4);
    @(negedge clk);
    chk("R5", 64'(bus_valid), 64'd1);
    chk("R5", 64'(bus_tag), 64'd2);
    chk("R5", bus_data, 64'd7);
    repeat (2) @(negedge clk);

    // R2/R8/R10: full adder class, divide by zero, WAW on r3
    cur_req = "R8";
    issue(2'd3, 3'd7, 3'd5, 3'd0);
    issue(2'd1, 3'd3, 3'd7, 3'd0);
    issue(2'd0, 3'd3, 3'd7, 3'd7);
    issue(2'd0, 3'd3, 3'd4, 3'd0);
    #2 iss_op = 2'd0;
    #1 chk("R2", 64'(iss_ready), 64'd0);
    iss_op = 2'd2;
    #1 chk("R2", 64'(iss_ready), 64'd1);
    iss_op = 2'd0;
    repeat (60) @(negedge clk);
    read_reg(3'd3, v);
    chk("R8", v, 64'd4);
    read_reg(3'd7, v);
    chk("R10", v, 64'hFFFF_FFFF_FFFF_FFFF);

    // R3: consumer issued during its producer's broadcast; R9 reuse
    cur_req = "R3";
    issue(2'd0, 3'd3, 3'd1, 3'd1);
    wait_bcast(t, v);
    chk("R3", 64'(t), 64'd1);
    issue(2'd0, 3'd4, 3'd3, 3'd0);
    issue(2'd0, 3'd5, 3'd0, 3'd0);
    wait_bcast(t, v);
    chk("R3", 64'(t), 64'd2);
    chk("R3", v, 64'd8);
    wait_bcast(t, v);
    chk("R9", 64'(t), 64'd1);
    chk("R9", v, 64'd0);
    repeat (5) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule